// File: doc/BRIEF.md
# Register File with Constant Generator

This block holds the sixteen 16-bit registers of a small microcontroller core. Most entries are plain storage, but three have fixed roles. Entry 0 holds the program counter. It is always even, and it can step forward by one instruction word or take a new target. Entry 2 holds the status flags and also supplies constants. Entry 3 stores nothing and only supplies constants.

The source read port takes a register index and the 2-bit source addressing-mode field of the instruction. For entries 2 and 3 it returns a generated constant in place of the stored value, so that common literals need no extra instruction word. A second read port returns the raw stored contents for the destination operand. A single write port stores results and applies the rules each special entry needs. Reads are combinational from the stored state. A write lands at the clock edge, so a read of the same index in the same cycle returns the old value.

Top module: `cg_regfile`

## Requirements
- R1: After reset, every entry reads 0000h on the raw port, and `pc_out` is 0000h.
- R2: A write to any of entries 4 to 15 stores `wr_data`. That entry then returns the value on the raw port and on the source port in every mode (codes 00, 01, 10, 11).
- R3: Entry 0 never holds an odd value. A value written through the write port or through `pc_load` is stored with bit 0 cleared.
- R4: `pc_inc` alone adds 2 to entry 0 at the clock edge, wrapping from FFFEh to 0000h.
- R5: Entry 0 takes its update in this order of priority: `pc_load`, then a write-port write to index 0, then `pc_inc`.
- R6: On the source port, index 3 returns 0000h for mode 00, 0001h for mode 01, 0002h for mode 10 and FFFFh for mode 11.
- R7: On the source port, index 2 returns the stored status value for mode 00 and 0000h for mode 01.
- R8: On the source port, index 2 returns 0004h for mode 10 and 0008h for mode 11.
- R9: Writes to index 3 are ignored. Afterwards the raw port still reads 0000h at index 3, and the source port still returns the R6 constants.
- R10: When a write and a read of the same index fall in the same cycle, the read returns the old value. The new value appears from the next cycle on.
- R11: The raw port ignores the mode field. At index 2 it returns the stored status value, and at index 3 it returns 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_idx | input | 4 | Source port register index |
| src_mode | input | 2 | Source addressing-mode field |
| src_data | output | 16 | Source operand or generated constant |
| dst_idx | input | 4 | Raw read port register index |
| dst_data | output | 16 | Raw stored contents |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 4 | Write register index |
| wr_data | input | 16 | Write data |
| pc_inc | input | 1 | Step the program counter by 2 |
| pc_load | input | 1 | Load the program counter |
| pc_load_val | input | 16 | Program counter target |
| pc_out | output | 16 | Current program counter |

## Verification
The bench sweeps every index against every mode on both read ports, so it catches a constant table with a swapped row or the wrong index. It also catches a status entry whose mode-00 path is masked to zero. It writes odd values into entry 0 through both paths, where a missing bit-0 clear would leave the counter odd. It runs the counter across FFFEh to check the wrap. It drives conflicting `pc_load`, write and `pc_inc` together, where a reversed priority would leave the wrong winner in entry 0. It writes to entry 3 and checks that the entry still reads zero, and it reads each entry in the cycle it is written to expose a read path that bypasses the register.

// File: rtl/cg_regfile_pkg.sv
package cg_regfile_pkg;
    localparam int PC_IDX = 0;
    localparam int SR_IDX = 2;
    localparam int CG_IDX = 3;

    typedef enum logic [1:0] {
        AM_DIRECT   = 2'b00,
        AM_OFFSET   = 2'b01,
        AM_POINTER  = 2'b10,
        AM_POSTINC  = 2'b11
    } src_mode_e;
endpackage

// File: rtl/cg_read_port.sv
module cg_read_port #(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 16,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
    input  logic [IDX_W-1:0]                idx,
    output logic [DATA_W-1:0]               data
);
    always_comb begin
        data = regs[idx];
    end
endmodule

// File: rtl/cg_const_gen.sv
module cg_const_gen
    import cg_regfile_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 16,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [1:0]        mode,
    input  logic [DATA_W-1:0] reg_val,
    output logic [DATA_W-1:0] operand
);
    always_comb begin
        operand = reg_val;
        if (idx == IDX_W'(CG_IDX)) begin
            unique case (src_mode_e'(mode))
                AM_DIRECT:  operand = '0;
                AM_OFFSET:  operand = DATA_W'(1);
                AM_POINTER: operand = DATA_W'(2);
                AM_POSTINC: operand = '1;
                default:    operand = '0;
            endcase
        end else if (idx == IDX_W'(SR_IDX)) begin
            unique case (src_mode_e'(mode))
                AM_DIRECT:  operand = reg_val;
                AM_OFFSET:  operand = '0;
                AM_POINTER: operand = DATA_W'(4);
                AM_POSTINC: operand = DATA_W'(8);
                default:    operand = reg_val;
            endcase
        end
    end
endmodule

// File: rtl/cg_pc_next.sv
module cg_pc_next #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] pc_q,
    input  logic              pc_inc,
    input  logic              pc_load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] pc_d
);
    localparam logic [DATA_W-1:0] EVEN_MASK = ~DATA_W'(1);
    localparam logic [DATA_W-1:0] STEP      = DATA_W'(2);

    always_comb begin
        if (pc_load) begin
            pc_d = load_val & EVEN_MASK;
        end else if (wr_hit) begin
            pc_d = wr_data & EVEN_MASK;
        end else if (pc_inc) begin
            pc_d = (pc_q + STEP) & EVEN_MASK;
        end else begin
            pc_d = pc_q & EVEN_MASK;
        end
    end
endmodule

// File: rtl/cg_regfile.sv
module cg_regfile
    import cg_regfile_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 16,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  src_idx,
    input  logic [1:0]        src_mode,
    output logic [DATA_W-1:0] src_data,
    input  logic [IDX_W-1:0]  dst_idx,
    output logic [DATA_W-1:0] dst_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pc_inc,
    input  logic              pc_load,
    input  logic [DATA_W-1:0] pc_load_val,
    output logic [DATA_W-1:0] pc_out
);
    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    } state_t;

    state_t st_d, st_q;
    logic [DATA_W-1:0] pc_nxt_d;
    logic [DATA_W-1:0] src_raw;
    logic              pc_wr_hit;

    assign pc_wr_hit = wr_en && (wr_idx == IDX_W'(PC_IDX));

    cg_pc_next #(.DATA_W(DATA_W)) u_pc_next (
        .pc_q     (st_q.regs[PC_IDX]),
        .pc_inc   (pc_inc),
        .pc_load  (pc_load),
        .load_val (pc_load_val),
        .wr_hit   (pc_wr_hit),
        .wr_data  (wr_data),
        .pc_d     (pc_nxt_d)
    );

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (i == PC_IDX) begin
                st_d.regs[i] = pc_nxt_d;
            end else if (i == CG_IDX) begin
                st_d.regs[i] = '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                st_d.regs[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    cg_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_src_port (
        .regs (st_q.regs),
        .idx  (src_idx),
        .data (src_raw)
    );

    cg_const_gen #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_const_gen (
        .idx     (src_idx),
        .mode    (src_mode),
        .reg_val (src_raw),
        .operand (src_data)
    );

    cg_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_dst_port (
        .regs (st_q.regs),
        .idx  (dst_idx),
        .data (dst_data)
    );

    assign pc_out = st_q.regs[PC_IDX];
endmodule

// File: rtl/cg_regfile_chk.sv
module cg_regfile_chk #(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 16,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [IDX_W-1:0]  src_idx,
    input logic [1:0]        src_mode,
    input logic [DATA_W-1:0] src_data,
    input logic [IDX_W-1:0]  dst_idx,
    input logic [DATA_W-1:0] dst_data,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic              pc_inc,
    input logic              pc_load,
    input logic [DATA_W-1:0] pc_load_val,
    input logic [DATA_W-1:0] pc_out
);
    p_pc_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pc_out[0] == 1'b0);

    p_pc_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> pc_out == ($past(pc_load_val) & ~DATA_W'(1)));

    p_pc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_inc && !pc_load && !(wr_en && wr_idx == '0))
        |=> pc_out == $past(pc_out) + DATA_W'(2));

    p_pc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_inc && !pc_load && !(wr_en && wr_idx == '0)) |=> $stable(pc_out));

    p_cg_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (src_idx == IDX_W'(3) && src_mode == 2'b00) |-> src_data == '0);

    p_cg_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (src_idx == IDX_W'(3) && src_mode == 2'b11) |-> src_data == '1);

    p_sr_abs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (src_idx == IDX_W'(2) && src_mode == 2'b01) |-> src_data == '0);

    p_r3_raw_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dst_idx == IDX_W'(3) |-> dst_data == '0);
endmodule

bind cg_regfile cg_regfile_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_chk (.*);

// File: tb/cg_regfile_tb.sv
module cg_regfile_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_idx = '0;
    logic [1:0]  src_mode = '0;
    logic [15:0] src_data;
    logic [3:0]  dst_idx = '0;
    logic [15:0] dst_data;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [15:0] wr_data = '0;
    logic        pc_inc = 1'b0;
    logic        pc_load = 1'b0;
    logic [15:0] pc_load_val = '0;
    logic [15:0] pc_out;

    int checks = 0;
    int fails = 0;
    logic [15:0] model [16];

    always #10 clk = ~clk;

    cg_regfile u_dut (.*);

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] src_expect(int idx, int mode);
        if (idx == 3) begin
            case (mode)
                0: return 16'h0000;
                1: return 16'h0001;
                2: return 16'h0002;
                default: return 16'hFFFF;
            endcase
        end
        if (idx == 2) begin
            case (mode)
                0: return model[2];
                1: return 16'h0000;
                2: return 16'h0004;
                default: return 16'h0008;
            endcase
        end
        return model[idx];
    endfunction

    task automatic tick();
        @(posedge clk);
        #3;
    endtask

    task automatic sweep(string tag);
        for (int i = 0; i < 16; i++) begin
            dst_idx = 4'(i);
            src_idx = 4'(i);
            for (int m = 0; m < 4; m++) begin
                src_mode = 2'(m);
                #1;
                check($sformatf("%s src idx %0d mode %0d", tag, i, m), src_data, src_expect(i, m));
                check($sformatf("%s raw idx %0d", tag, i), dst_data, model[i]);
            end
        end
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                fails++;
                $display("FAIL watchdog: actual %0d expected below 100000", cyc);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        tick(); tick();
        rst_n = 1'b1;
        #1;
        // R1 reset state and R6 constants after reset
        check("R1 pc_out", pc_out, 16'h0000);
        sweep("R1/R6");

        // R2 R3 R10: write every index, read-during-write shows old value
        for (int i = 0; i < 16; i++) begin
            logic [15:0] v;
            v = 16'(16'hA5C3 ^ (i * 16'h1357));
            wr_en = 1'b1; wr_idx = 4'(i); wr_data = v; dst_idx = 4'(i);
            #1;
            check($sformatf("R10 old value idx %0d", i), dst_data, model[i]);
            tick();
            wr_en = 1'b0;
            if (i == 0) model[0] = v & 16'hFFFE;
            else if (i != 3) model[i] = v;
            #1;
            check($sformatf("R10 new value idx %0d", i), dst_data, model[i]);
        end
        check("R3 pc even after odd write", pc_out, model[0]);
        // R2 R7 R8 R11 R9 full sweep with stored patterns
        sweep("R2/R7/R8/R11");

        // R3 load odd, R4 step
        pc_load = 1'b1; pc_load_val = 16'h1235; tick(); pc_load = 1'b0;
        check("R3 load clears bit0", pc_out, 16'h1234);
        pc_inc = 1'b1; tick(); tick(); tick(); pc_inc = 1'b0;
        check("R4 three steps", pc_out, 16'h123A);
        tick();
        check("R4 hold when idle", pc_out, 16'h123A);
        pc_load = 1'b1; pc_load_val = 16'hFFFE; tick(); pc_load = 1'b0;
        pc_inc = 1'b1; tick(); pc_inc = 1'b0;
        check("R4 wrap", pc_out, 16'h0000);

        // R5 priority
        pc_load = 1'b1; pc_load_val = 16'h4000; pc_inc = 1'b1;
        wr_en = 1'b1; wr_idx = 4'd0; wr_data = 16'h5000;
        tick();
        pc_load = 1'b0;
        check("R5 load beats write and step", pc_out, 16'h4000);
        wr_data = 16'h6001;
        tick();
        wr_en = 1'b0; pc_inc = 1'b0;
        check("R5 write beats step", pc_out, 16'h6000);
        model[0] = 16'h6000;

        // R9 write to index 3 ignored
        wr_en = 1'b1; wr_idx = 4'd3; wr_data = 16'hBEEF; tick(); wr_en = 1'b0;
        dst_idx = 4'd3; #1;
        check("R9 raw idx 3", dst_data, 16'h0000);
        sweep("R9");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule